// File: doc/BRIEF.md
# MII Management Frame Master

This block lets a host read and write PHY registers over a two-wire management link. The host raises `start_i` for one cycle with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then produces the whole serial frame on its own. It generates the management clock `mdc_o` from the system clock and shifts the frame out on `mdio_o`. When the PHY has to answer, it releases the data line through `mdio_oe_o` and samples `mdio_i`.

Each bit takes one cell: `mdc_o` is low for `HALF_DIV` system clocks and then high for `HALF_DIV` system clocks. The default of 20 gives 2.5 MHz from a 100 MHz system clock. The divider can be set large enough to stretch each phase to 10 us or longer. `busy_o` covers the whole frame. `done_o` pulses once when the final cell ends, and for a read `rd_data_o` is updated at that point.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, and at any time no frame is in progress, `mdc_o`, `mdio_oe_o`, `busy_o` and `done_o` are all low.
- R2: Every frame starts with 32 one-bits, followed MSB first by the 4-bit code 0110 for a read (`wr_i`=0) or 0101 for a write (`wr_i`=1).
- R3: The next 10 bits are the PHY address and then the register address, each sent MSB first.
- R4: A write frame continues with the bits 1,0, then `wr_data_i` MSB first, then two one-bits, for 66 cells in total, with `mdio_oe_o` high in every cell.
- R5: A read frame has 63 cells. `mdio_oe_o` is high for the first 46 cells and low for the last 17. The 17 bits sampled in those cells arrive MSB first; the first one is dropped and the last 16 become `rd_data_o`.
- R6: `mdc_o` stays low for exactly `HALF_DIV` system clocks and then high for exactly `HALF_DIV` system clocks in every cell. `mdio_o` changes only while `mdc_o` is low. `mdio_i` is sampled in the last low cycle, before the rising edge.
- R7: A `start_i` accepted while idle raises `busy_o` on the next clock. A `start_i` while `busy_o` is high is ignored: it starts no frame and does not change the running one.
- R8: `done_o` is high for exactly one cycle after the high phase of the final cell. `busy_o` falls on the same edge.
- R9: `rd_data_o` changes only when a read frame completes. A write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a frame |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Data for a write frame |
| rd_data_o | output | 16 | Register value from the last read frame |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe_o | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Serial data sampled from the line |

## Verification
The bench builds the block with `HALF_DIV` set to 3. That gives 6-cycle bit cells, so a full write frame lasts about 400 system clocks. Many frames therefore fit in the run, including back-to-back requests and a start pulse in the middle of a frame. An odd value above 1 also means that a phase counter off by one shows up as a wrong low or high run length on `mdc_o`. A PHY model drives the line only while the output enable is low, and it changes its bit just after each rising edge. A design that samples late therefore reads shifted data, including the turnaround bit that should be dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN = 32;
  localparam int OP_LEN  = 4;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int HDR_LEN = PRE_LEN + OP_LEN + 2 * ADDR_W;
  localparam int WR_LEN  = HDR_LEN + 2 + DATA_W + 2;
  localparam int RD_LEN  = HDR_LEN + DATA_W + 1;
  localparam int FRAME_W = WR_LEN;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [OP_LEN-1:0] OP_RD = 4'b0110;
  localparam logic [OP_LEN-1:0] OP_WR = 4'b0101;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             phase_end;

  assign phase_end = run_i && (cnt_q == CNT_MAX);
  assign rise_o    = phase_end && !mdc_q;
  assign fall_o    = phase_end && mdc_q;
  assign mdc_o     = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R6
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mdio_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] WR_LAST = IDX_W'(WR_LEN - 1);
  localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(RD_LEN - 1);

  logic [FRAME_W-1:0] tx_q;
  logic [FRAME_W-1:0] frame_d;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_idx;
  logic [DATA_W-1:0]  rx_q;
  logic [DATA_W-1:0]  rd_q;
  logic               busy_q;
  logic               done_q;
  logic               wr_q;

  always_comb begin
    if (wr_i)
      frame_d = {{PRE_LEN{1'b1}}, OP_WR, phy_addr_i, reg_addr_i, 2'b10, wr_data_i, 2'b11};
    else
      frame_d = {{PRE_LEN{1'b1}}, OP_RD, phy_addr_i, reg_addr_i, {(FRAME_W-HDR_LEN){1'b0}}};
  end

  assign last_idx  = wr_q ? WR_LAST : RD_LAST;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_data_o = rd_q;
  assign mdio_o    = tx_q[FRAME_W-1];
  // line released during the read turnaround and data cells
  assign mdio_oe_o = busy_q && (wr_q || (idx_q < HDR_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          wr_q   <= wr_i;
          tx_q   <= frame_d;
          idx_q  <= '0;
        end
      end else begin
        if (rise_i && !wr_q && (idx_q >= HDR_IDX))
          rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        if (fall_i) begin
          if (idx_q == last_idx) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (!wr_q) rd_q <= rx_q;
          end else begin
            idx_q <= idx_q + 1'b1;
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(wr_q));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_q) |-> done_q);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic rise_w;
  logic fall_w;

  mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .mdc_o  (mdc_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wr_i       (wr_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wr_data_i  (wr_data_i),
    .mdio_i     (mdio_i),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_data_o  (rd_data_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
  import mdio_pkg::*;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  pa = '0;
  logic [4:0]  ra = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd_data;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe;
  logic        mdio_line;
  logic        phy_bit;
  logic [16:0] phy_word = '0;
  int          rd_cnt = 0;

  always #5 clk = ~clk;

  always_comb phy_bit = (rd_cnt < 17) ? phy_word[16 - rd_cnt] : 1'b1;
  assign mdio_line = mdio_oe ? mdio_o : phy_bit;

  mdio_frame_master #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr),
    .phy_addr_i(pa), .reg_addr_i(ra), .wr_data_i(wd),
    .rd_data_o(rd_data), .busy_o(busy_o), .done_o(done_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_line)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [65:0] q_bits[$];
  int          q_len[$];
  int          q_oe[$];
  logic [15:0] q_rd[$];
  bit          q_isrd[$];
  logic [15:0] last_rd = '0;

  task automatic send(input bit w, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d, input logic [16:0] pw);
    logic [65:0] e;
    while (busy_o) @(negedge clk);
    if (w) begin
      e = {32'hFFFF_FFFF, 4'b0101, p, r, 2'b10, d, 2'b11};
      q_len.push_back(66); q_oe.push_back(66);
    end else begin
      e = {3'b000, 32'hFFFF_FFFF, 4'b0110, p, r, pw};
      q_len.push_back(63); q_oe.push_back(46);
      last_rd = pw[15:0];
    end
    q_bits.push_back(e); q_rd.push_back(last_rd); q_isrd.push_back(!w);
    phy_word = pw;
    wr = w; pa = p; ra = r; wd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b1, "R7", "busy one cycle after start", 66'(busy_o), 66'd1);
  endtask

  // monitor
  logic [65:0] cap = '0;
  int n = 0, oe_n = 0, run = 0;
  bit per_bad = 0, prev_mdc = 0, prev_done = 0;

  always @(negedge clk) begin
    logic [65:0] t_act, t_exp, msk;
    int len;
    if (rst_n) begin
      if (busy_o) begin
        if (mdc_o == prev_mdc) run++;
        else begin
          if (run != HALF) per_bad = 1;
          run = 1;
        end
        if (mdc_o && !prev_mdc) begin
          cap = {cap[64:0], mdio_line};
          n++;
          if (mdio_oe) oe_n++;
          else rd_cnt++;
        end
      end else begin
        if (prev_mdc && run != HALF) per_bad = 1;
        run = 0;
        rd_cnt = 0;
      end
      if (prev_done && done_o)
        check(0, "R8", "done longer than one cycle", 66'd1, 66'd0);
      if (done_o) begin
        check(!busy_o, "R8", "busy low at done", 66'(busy_o), 66'd0);
        if (q_len.size() == 0) begin
          check(0, "R7", "frame without accepted start", 66'(n), 66'd0);
        end else begin
          len = q_len.pop_front();
          t_exp = q_bits.pop_front();
          check(n == len, q_isrd[0] ? "R5" : "R4", "cell count", 66'(n), 66'(len));
          if (n == len) begin
            t_act = cap >> (len - 36); msk = t_exp >> (len - 36);
            check(t_act[35:0] == msk[35:0], "R2", "preamble and opcode",
                  66'(t_act[35:0]), 66'(msk[35:0]));
            t_act = cap >> (len - 46); msk = t_exp >> (len - 46);
            check(t_act[9:0] == msk[9:0], "R3", "addresses",
                  66'(t_act[9:0]), 66'(msk[9:0]));
            msk = (66'd1 << (len - 46)) - 66'd1;
            check((cap & msk) == (t_exp & msk), q_isrd[0] ? "R5" : "R4", "tail bits",
                  cap & msk, t_exp & msk);
          end
          len = q_oe.pop_front();
          check(oe_n == len, q_isrd[0] ? "R5" : "R4", "driven cells", 66'(oe_n), 66'(len));
          t_exp = 66'(q_rd.pop_front());
          check(66'(rd_data) == t_exp, q_isrd[0] ? "R5" : "R9", "rd_data",
                66'(rd_data), t_exp);
          void'(q_isrd.pop_front());
          check(!per_bad, "R6", "mdc phase length", 66'(per_bad), 66'd0);
        end
        cap = '0; n = 0; oe_n = 0; per_bad = 0;
      end
      prev_mdc = mdc_o;
      prev_done = done_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mdc_o && !mdio_oe && !busy_o && !done_o, "R1", "reset outputs",
          66'({mdc_o, mdio_oe, busy_o, done_o}), 66'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mdc_o && !busy_o, "R1", "idle after reset", 66'({mdc_o, busy_o}), 66'd0);

    send(1, 5'h01, 5'h04, 16'hA5C3, 17'h0);
    send(1, 5'h1F, 5'h00, 16'hFFFF, 17'h0);
    send(0, 5'h02, 5'h11, 16'h0, 17'h0_1234);
    send(0, 5'h15, 5'h1E, 16'h0, 17'h1_BEEF);  // turnaround bit set, must be dropped
    send(1, 5'h0A, 5'h15, 16'h0001, 17'h0);    // R9 rd_data stays BEEF

    // R7 start pulses while busy must be ignored
    send(1, 5'h03, 5'h07, 16'h8000, 17'h0);
    repeat (20) @(negedge clk);
    wr = 1'b0; pa = 5'h1C; ra = 5'h03; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (10) @(negedge clk);
    check(!busy_o, "R7", "no frame from ignored start", 66'(busy_o), 66'd0);

    // back to back reads
    send(0, 5'h00, 5'h00, 16'h0, 17'h0_0000);
    send(0, 5'h10, 5'h01, 16'h0, 17'h0_FFFF);
    send(1, 5'h11, 5'h1F, 16'h5A5A, 17'h0);

    while (q_len.size() > 0 || busy_o) @(negedge clk);
    repeat (5) @(negedge clk);
    check(!mdc_o && !mdio_oe && !done_o, "R1", "idle after frames",
          66'({mdc_o, mdio_oe, done_o}), 66'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule